// File: doc/BRIEF.md
# Quadrature NCO Complex Mixer

This block moves a chosen frequency channel down to DC. A 32-bit phase accumulator drives a quadrature oscillator. Each incoming sample is multiplied by the conjugate of the oscillator phasor, which rotates the spectrum by minus the tuned frequency. At a 52 MHz sample clock one least-significant step of the phase increment is about 0.012 Hz. The block accepts one sample per clock.

The input is either a real stream or a complex I/Q stream, 10 bits per component in two's complement, qualified by a valid strobe. A small write port sets three values:
- the phase increment,
- a static phase offset,
- the input mode.

Sine and cosine come from a quarter-wave table that is computed when the design is elaborated. The results are rounded and clamped to a fixed output width, and they leave the block with a valid strobe that follows the input strobe.

Top module: `nco_mixer`

## Requirements
- R1: While rst_ni is low and after it rises, out_valid_o is 0 and out_i_o/out_q_o are 0 until the first result leaves the pipeline; every configuration value resets to 0, which selects real mode.
- R2: out_valid_o goes high exactly 4 clock cycles after the cycle in which in_valid_i was high, once for each input sample, with back-to-back samples accepted every cycle.
- R3: For sample phase p, with c = round(2047·cos(2πp)) and s = round(2047·sin(2πp)), out_i = floor((xi·c + xq·s + 1024) / 2048) and out_q = floor((xq·c − xi·s + 1024) / 2048).
- R4: When mode bit 0 (register address 2) is 0 the block is in real mode: in_q_i is ignored and treated as zero, giving out_i from x·cos and out_q from −x·sin. Writing 1 to that bit selects complex mode.
- R5: The phase accumulator is 32 bits wide and wraps modulo 2^32. It advances by the increment (register address 0) only after a cycle with in_valid_i high. The first sample after reset sees an accumulated phase of 0.
- R6: The phase used by a sample is the top 10 bits of (accumulator + offset), where the offset is register address 1. The table reaches exactly ±2047 or 0 at multiples of a quarter turn, and it is mirrored to cover all four quadrants.
- R7: A new increment applies from the advance that follows the next valid sample, and the phase already accumulated is kept.
- R8: Results beyond the signed 10-bit output range are clamped to 511 or −512 and never wrap around.
- R9: While out_valid_o is low, out_i_o and out_q_o hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register select: 0 increment, 1 offset, 2 mode |
| cfg_wdata_i | input | 32 | Write data |
| in_valid_i | input | 1 | Input sample valid |
| in_i_i | input | 10 | In-phase or real input sample |
| in_q_i | input | 10 | Quadrature input sample (complex mode) |
| out_valid_o | output | 1 | Output sample valid |
| out_i_o | output | 10 | Mixed in-phase output |
| out_q_o | output | 10 | Mixed quadrature output |

## Verification
The checker watches four things on every cycle:
- the 4-cycle alignment of the output strobe with the input strobe,
- that the accumulator does not move on idle cycles,
- that the outputs hold while no result is valid,
- that the table returns a zero in sine or cosine at every quadrant boundary and never goes past ±2047.

Only the bench scenarios can show the following:
- the arithmetic values of the products and their rounding,
- clamping when the full-scale corner is mixed at 45°,
- that the Q input is ignored in real mode,
- wrap-around of the phase,
- that a new increment leaves the accumulated phase intact.

// File: rtl/nco_mixer_pkg.sv
package nco_mixer_pkg;
  typedef enum logic [1:0] {
    REG_INC  = 2'd0,
    REG_OFS  = 2'd1,
    REG_MODE = 2'd2
  } cfg_reg_e;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic [PHASE_W-1:0] inc_i,
  input  logic [PHASE_W-1:0] ofs_i,
  output logic [PHASE_W-1:0] acc_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [PHASE_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (adv_i) acc_q <= acc_q + inc_i;
  end

  assign acc_o = acc_q;
  // only the top bits address the table; the rest are truncated
  assign idx_o = IDX_W'((acc_q + ofs_i) >> (PHASE_W - IDX_W));
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int IDX_W  = 10,
  parameter int COEF_W = 12
) (
  input  logic [IDX_W-1:0]         idx_i,
  output logic signed [COEF_W-1:0] sin_o,
  output logic signed [COEF_W-1:0] cos_o
);
  localparam int  QN  = 2 ** (IDX_W - 2);
  localparam int  AMP = 2 ** (COEF_W - 1) - 1;
  localparam real PI  = 3.14159265358979323846;

  // QN+1 entries so that sin(90 deg) is reached exactly
  logic [COEF_W-2:0] rom [0:QN];

  for (genvar k = 0; k <= QN; k++) begin : g_rom
    localparam real ANG = PI * k / (2.0 * QN);
    localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
    assign rom[k] = VAL[COEF_W-2:0];
  end

  logic [1:0]       quad_s, quad_c;
  logic [IDX_W-3:0] rem;
  logic [IDX_W-2:0] fwd, rev;
  logic [COEF_W-2:0] mag_s, mag_c;

  assign quad_s = idx_i[IDX_W-1:IDX_W-2];
  assign quad_c = quad_s + 2'd1;          // cos = sin shifted a quarter turn
  assign rem    = idx_i[IDX_W-3:0];
  assign fwd    = (IDX_W-1)'(rem);
  assign rev    = (IDX_W-1)'(QN) - fwd;

  always_comb begin
    mag_s = quad_s[0] ? rom[rev] : rom[fwd];
    mag_c = quad_c[0] ? rom[rev] : rom[fwd];
    sin_o = quad_s[1] ? -$signed({1'b0, mag_s}) : $signed({1'b0, mag_s});
    cos_o = quad_c[1] ? -$signed({1'b0, mag_c}) : $signed({1'b0, mag_c});
  end
endmodule

// File: rtl/cmix_core.sv
module cmix_core #(
  parameter int DATA_W = 10,
  parameter int COEF_W = 12,
  parameter int OUT_W  = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] xi_i,
  input  logic signed [DATA_W-1:0] xq_i,
  input  logic signed [COEF_W-1:0] cos_i,
  input  logic signed [COEF_W-1:0] sin_i,
  output logic                     valid_o,
  output logic signed [OUT_W-1:0]  yi_o,
  output logic signed [OUT_W-1:0]  yq_o
);
  localparam int PW = DATA_W + COEF_W;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (COEF_W - 2));
  localparam logic signed [SW-1:0] MAXO = SW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [SW-1:0] MINO = -MAXO - SW'(1);

  logic signed [PW-1:0] p_ic, p_qs, p_qc, p_is;
  logic                 v_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_ic <= '0; p_qs <= '0; p_qc <= '0; p_is <= '0;
      v_p  <= 1'b0;
    end else begin
      v_p <= valid_i;
      if (valid_i) begin
        p_ic <= xi_i * cos_i;
        p_qs <= xq_i * sin_i;
        p_qc <= xq_i * cos_i;
        p_is <= xi_i * sin_i;
      end
    end
  end

  logic signed [SW-1:0] sum_i, sum_q, sh_i, sh_q;
  logic signed [OUT_W-1:0] sat_i, sat_q;

  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [SW-1:0] v);
    if (v > MAXO)      return MAXO[OUT_W-1:0];
    else if (v < MINO) return MINO[OUT_W-1:0];
    else               return v[OUT_W-1:0];
  endfunction

  always_comb begin
    sum_i = p_ic + p_qs;                  // multiply by e^{-j phase}
    sum_q = p_qc - p_is;
    sh_i  = (sum_i + HALF) >>> (COEF_W - 1);
    sh_q  = (sum_q + HALF) >>> (COEF_W - 1);
    sat_i = clamp(sh_i);
    sat_q = clamp(sh_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      yi_o    <= '0;
      yq_o    <= '0;
    end else begin
      valid_o <= v_p;
      if (v_p) begin
        yi_o <= sat_i;
        yq_o <= sat_q;
      end
    end
  end
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_mixer_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int OUT_W   = 10,
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 8,
  parameter int COEF_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [1:0]               cfg_addr_i,
  input  logic [PHASE_W-1:0]       cfg_wdata_i,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_i_i,
  input  logic signed [DATA_W-1:0] in_q_i,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  out_i_o,
  output logic signed [OUT_W-1:0]  out_q_o
);
  localparam int IDX_W = LUT_AW + 2;

  logic [PHASE_W-1:0] inc_q, ofs_q;
  logic               cplx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q  <= '0;
      ofs_q  <= '0;
      cplx_q <= 1'b0;
    end else if (cfg_we_i) begin
      case (cfg_reg_e'(cfg_addr_i))
        REG_INC:  inc_q  <= cfg_wdata_i;
        REG_OFS:  ofs_q  <= cfg_wdata_i;
        REG_MODE: cplx_q <= cfg_wdata_i[0];
        default:  ;
      endcase
    end
  end

  logic [PHASE_W-1:0] acc_w;
  logic [IDX_W-1:0]   idx_w;

  nco_phase_acc #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (in_valid_i),
    .inc_i  (inc_q),
    .ofs_i  (ofs_q),
    .acc_o  (acc_w),
    .idx_o  (idx_w)
  );

  // stage 1: capture sample and phase
  logic                     v_s1;
  logic signed [DATA_W-1:0] xi_s1, xq_s1;
  logic [IDX_W-1:0]         idx_s1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_s1 <= 1'b0; xi_s1 <= '0; xq_s1 <= '0; idx_s1 <= '0;
    end else begin
      v_s1 <= in_valid_i;
      if (in_valid_i) begin
        xi_s1  <= in_i_i;
        xq_s1  <= cplx_q ? in_q_i : '0;
        idx_s1 <= idx_w;
      end
    end
  end

  logic signed [COEF_W-1:0] lut_sin, lut_cos;

  nco_sincos #(.IDX_W(IDX_W), .COEF_W(COEF_W)) i_lut (
    .idx_i (idx_s1),
    .sin_o (lut_sin),
    .cos_o (lut_cos)
  );

  // stage 2: register table output
  logic                     v_s2;
  logic signed [DATA_W-1:0] xi_s2, xq_s2;
  logic signed [COEF_W-1:0] cos_s2, sin_s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_s2 <= 1'b0; xi_s2 <= '0; xq_s2 <= '0; cos_s2 <= '0; sin_s2 <= '0;
    end else begin
      v_s2 <= v_s1;
      if (v_s1) begin
        xi_s2  <= xi_s1;
        xq_s2  <= xq_s1;
        cos_s2 <= lut_cos;
        sin_s2 <= lut_sin;
      end
    end
  end

  // stages 3 and 4: products, then round and clamp
  cmix_core #(.DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v_s2),
    .xi_i    (xi_s2),
    .xq_i    (xq_s2),
    .cos_i   (cos_s2),
    .sin_i   (sin_s2),
    .valid_o (out_valid_o),
    .yi_o    (out_i_o),
    .yq_o    (out_q_o)
  );
endmodule

// File: rtl/nco_mixer_chk.sv
module nco_mixer_chk #(
  parameter int OUT_W   = 10,
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 8,
  parameter int COEF_W  = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic                     out_valid_o,
  input logic signed [OUT_W-1:0]  out_i_o,
  input logic signed [OUT_W-1:0]  out_q_o,
  input logic [PHASE_W-1:0]       acc_i,
  input logic [LUT_AW+1:0]        idx_i,
  input logic signed [COEF_W-1:0] sin_i,
  input logic signed [COEF_W-1:0] cos_i
);
  localparam logic signed [COEF_W-1:0] AMP = COEF_W'(2 ** (COEF_W - 1) - 1);

  logic [3:0] vpipe;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vpipe <= '0;
    else         vpipe <= {vpipe[2:0], in_valid_i};
  end

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == vpipe[3]);

  assert_acc_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(acc_i));

  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(out_i_o) && $stable(out_q_o)));

  assert_quadrant_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i[LUT_AW-1:0] == '0) |-> (sin_i == '0 || cos_i == '0));

  assert_lut_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sin_i <= AMP) && (sin_i >= -AMP) && (cos_i <= AMP) && (cos_i >= -AMP));
endmodule

bind nco_mixer nco_mixer_chk #(
  .OUT_W(OUT_W), .PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .COEF_W(COEF_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .out_i_o     (out_i_o),
  .out_q_o     (out_q_o),
  .acc_i       (acc_w),
  .idx_i       (idx_s1),
  .sin_i       (lut_sin),
  .cos_i       (lut_cos)
);

// File: tb/test_nco_mixer.sv
module test_nco_mixer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic signed [9:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [9:0] out_i, out_q;

  always #4 clk = ~clk;

  nco_mixer i_nco_mixer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .in_valid_i(in_valid), .in_i_i(in_i), .in_q_i(in_q),
    .out_valid_o(out_valid), .out_i_o(out_i), .out_q_o(out_q)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int obs_i [256], obs_q [256], obs_t [256];
  int exp_i [256], exp_q [256], exp_t [256];
  int n_obs = 0, n_exp = 0, n_done = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && n_obs < 256) begin
      obs_i[n_obs] = int'(out_i);
      obs_q[n_obs] = int'(out_q);
      obs_t[n_obs] = cyc;
      n_obs++;
    end
  end

  // bench model state
  logic [31:0] m_ph = '0, m_inc = '0, m_ofs = '0;
  bit m_cplx = 0;
  localparam real PI = 3.14159265358979323846;

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int sat10(longint v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return int'(v);
  endfunction

  task automatic check(string tag, bit ok, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    case (a)
      2'd0: m_inc = d;
      2'd1: m_ofs = d;
      2'd2: m_cplx = d[0];
      default: ;
    endcase
  endtask

  // one cycle of input; v=0 drives idle with noisy data
  task automatic drive(input bit v, input int xi, input int xq);
    logic [31:0] p;
    int idx, c, s, xqe;
    longint si, sq;
    @(negedge clk);
    cfg_we = 1'b0;
    in_valid = v;
    in_i = 10'(xi);
    in_q = 10'(xq);
    if (v) begin
      p   = m_ph + m_ofs;
      idx = int'(p >> 22);
      c   = rnd(2047.0 * $cos(2.0 * PI * idx / 1024.0));
      s   = rnd(2047.0 * $sin(2.0 * PI * idx / 1024.0));
      xqe = m_cplx ? xq : 0;
      si  = longint'(xi) * c + longint'(xqe) * s;
      sq  = longint'(xqe) * c - longint'(xi) * s;
      exp_i[n_exp] = sat10((si + 1024) >>> 11);
      exp_q[n_exp] = sat10((sq + 1024) >>> 11);
      exp_t[n_exp] = cyc;
      n_exp++;
      m_ph = m_ph + m_inc;
    end
  endtask

  task automatic flush(string tag);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    repeat (6) @(negedge clk);
    check(tag, n_obs == n_exp, "output count", n_obs, n_exp);
    for (int k = n_done; k < n_exp && k < n_obs; k++) begin
      check(tag, obs_i[k] == exp_i[k], $sformatf("I of sample %0d", k), obs_i[k], exp_i[k]);
      check(tag, obs_q[k] == exp_q[k], $sformatf("Q of sample %0d", k), obs_q[k], exp_q[k]);
      check("R2", obs_t[k] - exp_t[k] == 4, $sformatf("latency of sample %0d", k),
            obs_t[k] - exp_t[k], 4);
    end
    n_done = n_exp;
    n_obs  = n_exp;
  endtask

  task automatic t_reset;  // R1
    @(negedge clk);
    check("R1", out_valid == 1'b0, "valid after reset", int'(out_valid), 0);
    check("R1", out_i == 0 && out_q == 0, "outputs after reset", int'(out_i), 0);
  endtask

  task automatic t_real_quarter;  // R4 R5 R6: quarter steps, wrap past 2^32, Q ignored
    cfg(2'd0, 32'h4000_0000);
    for (int k = 0; k < 6; k++) drive(1, 500, 300 - 100 * k);
    flush("R4");
    check("R5", obs_i[4] == obs_i[0] && obs_q[4] == obs_q[0], "phase wrap repeat",
          obs_i[4], obs_i[0]);
    check("R6", obs_q[0] == 0 && obs_i[1] == 0, "quarter points exact", obs_q[0], 0);
  endtask

  task automatic t_saturate;  // R8 R3: 45 deg with full-scale corner
    cfg(2'd2, 32'd1);
    cfg(2'd0, 32'd0);
    cfg(2'd1, 32'h2000_0000 - m_ph);  // make phase exactly 1/8 turn
    drive(1, 511, 511);
    drive(1, -512, -512);
    drive(1, 100, -50);
    flush("R8");
    check("R8", obs_i[n_done-3] == 511, "positive clamp", obs_i[n_done-3], 511);
    check("R8", obs_i[n_done-2] == -512, "negative clamp", obs_i[n_done-2], -512);
  endtask

  task automatic t_gaps;  // R3 R5 R2: arbitrary step, idle gaps, back-to-back
    cfg(2'd1, 32'h0);
    cfg(2'd0, 32'h0123_4567);
    drive(1, 200, -100);
    drive(0, 77, -33);
    drive(0, -400, 250);
    drive(1, -300, 150);
    drive(1, 45, 400);
    drive(1, -511, -7);
    drive(0, 1, 1);
    drive(1, 123, -456);
    flush("R3");
  endtask

  task automatic t_inc_change;  // R7: new increment keeps accumulated phase
    cfg(2'd0, 32'h1000_0000);
    drive(1, 400, 0);
    drive(1, 400, 0);
    cfg(2'd0, 32'h4000_0000);
    drive(1, 400, 0);
    drive(1, 400, 0);
    drive(1, 400, 0);
    flush("R7");
  endtask

  task automatic t_hold;  // R9: outputs frozen while idle
    int li, lq;
    li = obs_i[n_done-1];
    lq = obs_q[n_done-1];
    for (int k = 0; k < 5; k++) drive(0, 100 * k - 250, 37 * k);
    @(negedge clk);
    check("R9", out_valid == 1'b0, "valid while idle", int'(out_valid), 0);
    check("R9", int'(out_i) == li, "I held", int'(out_i), li);
    check("R9", int'(out_q) == lq, "Q held", int'(out_q), lq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", out_valid == 1'b0, "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    t_reset();
    t_real_quarter();
    t_saturate();
    t_gaps();
    t_inc_change();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule